// File: doc/BRIEF.md
# Universal serial shift interface

This block is a software-assisted serial shifter that serves three-wire (SPI-like) and two-wire (I2C-like) links in either master or slave role. Software writes the outgoing byte straight into an 8-bit shift register. The shift register moves one place left on every sampling clock edge. A buffer register captures each finished byte, so the received value can be read after the next transfer has begun. A 4-bit edge counter counts both clock edges, which means one byte takes sixteen edges. When the counter wraps, it raises an overflow flag.

The shift clock comes from one of three sources: software strobes, the external clock pin, or timer compare events. Each software strobe or timer event toggles an internal clock level, and that level is also driven out as the master clock. The outgoing bit comes from the register's top bit. It passes through a latch that is transparent only while the clock is low, so the pin changes on the falling phase and stays fixed while the far end samples.

In two-wire mode, both lines are open drain: the block only ever asks for a pin to be pulled low. A start-condition detector watches the data line for a fall while the clock line is high. A hold state machine stretches the clock line low after a start condition (slave role) or after a byte overflow, and keeps it low until software clears the matching flag. Byte-level protocol work such as addressing and acknowledge policy is left to software.

Top module: `sershift_unit`

## Requirements
- R1: After reset, data, buffer and counter are 0, both flags and irq are 0, do_pin is 1, sck_out is 1, and neither drive-low output is asserted.
- R2: A host write to the data register or to the counter shows on data_q or cnt_q after the next clock edge. A host write takes priority over a shift or a count in the same cycle.
- R3: The counter advances by one on every active edge of the selected clock, rising or falling. From 15 it wraps to 0 and sets the overflow flag.
- R4: On each rising edge of the selected clock, the data register shifts left by one. The new bit 0 comes from di_pin in three-wire mode and from sda_pin in two-wire mode. Bits are sent and received MSB first.
- R5: When the counter overflows, the buffer register captures the data register value that includes the final shift.
- R6: The serial output bit follows data bit 7 only while the selected clock is low. While the clock is high, it holds its value even if the host writes the data register.
- R7: clk_src selects the clock source: 0 = software strobe, 1 = clock pin, 2 = timer match, 3 = stopped. Strobes and timer events from an unselected source have no effect.
- R8: In two-wire mode, sda_drive_low equals the inverse of the output bit and do_pin is 0. In three-wire mode, do_pin carries the output bit and neither drive-low output is asserted.
- R9: In two-wire mode, a fall of sda_pin while sclk_pin is high sets the start flag. In three-wire mode, the start flag never sets.
- R10: The hold state machine has three states: FREE, START_HOLD and OVF_HOLD. It moves from FREE to START_HOLD when the start flag is set in two-wire pin-clocked mode, and from FREE to OVF_HOLD when the overflow flag is set in two-wire mode. START_HOLD takes priority. The machine returns to FREE (or to OVF_HOLD if overflow is still pending) once the flag that caused the hold is cleared, and it drops to FREE whenever three-wire mode is selected. While the machine is not in FREE, scl_drive_low is 1.
- R11: A flag that is set and cleared in the same cycle ends up set. irq is the OR of the start flag gated by start_ie and the overflow flag gated by ovf_ie.
- R12: With an internal clock source, sck_out equals the internal clock level, which idles high. In two-wire mode, scl_drive_low is 1 while that level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_wire | input | 1 | 1 = two-wire open-drain mode, 0 = three-wire mode |
| clk_src | input | 2 | Shift clock source select |
| sw_strobe | input | 1 | Software clock strobe, one toggle per cycle high |
| tmr_match | input | 1 | Timer compare event, one toggle per cycle high |
| wr_data_en | input | 1 | Host write enable for the data register |
| wr_data | input | 8 | Host write value for the data register |
| wr_cnt_en | input | 1 | Host write enable for the edge counter |
| wr_cnt | input | 4 | Host write value for the edge counter |
| clr_start | input | 1 | Clears the start flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| start_ie | input | 1 | Start interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| di_pin | input | 1 | Three-wire serial data input |
| sda_pin | input | 1 | Two-wire data line level |
| sclk_pin | input | 1 | External clock line level (USCK/SCL) |
| data_q | output | 8 | Data register contents |
| buf_q | output | 8 | Buffer register contents |
| cnt_q | output | 4 | Edge counter value |
| start_flag | output | 1 | Start condition detected |
| ovf_flag | output | 1 | Counter overflow |
| irq | output | 1 | Combined interrupt request |
| do_pin | output | 1 | Three-wire serial data output |
| sda_drive_low | output | 1 | Pull the two-wire data line low |
| scl_drive_low | output | 1 | Pull the two-wire clock line low |
| sck_out | output | 1 | Master clock level from the internal source |

## Verification
The counter overflow and a software clear of the overflow flag can land on the same clock edge. The bench provokes this by presetting the counter to 15 and then raising the final strobe and clr_ovf in the same cycle. The flag must still read set afterwards, and irq must follow it under ovf_ie. A second collision is a host counter write arriving in the same cycle as a strobe. Here the written value must win over the increment.

// File: rtl/sershift_pkg.sv
package sershift_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_PIN   = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_OFF   = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        HOLD_FREE  = 2'd0,
        HOLD_START = 2'd1,
        HOLD_OVF   = 2'd2
    } hold_state_e;

endpackage

// File: rtl/sershift_edge_gen.sv
module sershift_edge_gen
    import sershift_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     sw_strobe,
    input  logic     tmr_match,
    input  logic     sclk_pin,
    input  logic     sda_pin,
    input  logic     di_pin,
    output logic     sample_edge,
    output logic     output_edge,
    output logic     phase_high,
    output logic     int_clk,
    output logic     scl_s,
    output logic     sda_s,
    output logic     di_s,
    output logic     sda_fall
);
    // SYNC_STAGES must be at least 2
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync, di_sync;
    logic scl_prev, sda_prev;
    logic int_tick, pin_rise, pin_fall;

    assign int_tick = ((src == SRC_SOFT) && sw_strobe) || ((src == SRC_TIMER) && tmr_match);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            di_sync  <= '0;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
            int_clk  <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], sclk_pin};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_pin};
            di_sync  <= {di_sync[SYNC_STAGES-2:0], di_pin};
            scl_prev <= scl_sync[SYNC_STAGES-1];
            sda_prev <= sda_sync[SYNC_STAGES-1];
            int_clk  <= int_clk ^ int_tick;
        end
    end

    assign scl_s    = scl_sync[SYNC_STAGES-1];
    assign sda_s    = sda_sync[SYNC_STAGES-1];
    assign di_s     = di_sync[SYNC_STAGES-1];
    assign pin_rise = scl_s && !scl_prev;
    assign pin_fall = !scl_s && scl_prev;
    assign sda_fall = !sda_s && sda_prev;

    always_comb begin
        if (src == SRC_PIN) begin
            sample_edge = pin_rise;
            output_edge = pin_fall;
            phase_high  = scl_s;
        end else begin
            sample_edge = int_tick && !int_clk;
            output_edge = int_tick && int_clk;
            phase_high  = int_clk;
        end
    end
endmodule

// File: rtl/sershift_datapath.sv
module sershift_datapath #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_cnt_en,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic              sample_edge,
    input  logic              output_edge,
    input  logic              phase_high,
    input  logic              serial_in,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] buf_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              out_bit,
    output logic              ovf_event
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic              any_edge;
    logic [DATA_W-1:0] data_next;

    assign any_edge  = sample_edge || output_edge;
    assign data_next = sample_edge ? {data_q[DATA_W-2:0], serial_in} : data_q;
    assign ovf_event = any_edge && (cnt_q == '1) && !wr_cnt_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            buf_q   <= '0;
            cnt_q   <= '0;
            out_bit <= 1'b1;
        end else begin
            data_q <= wr_data_en ? wr_data : data_next;
            if (ovf_event) buf_q <= data_next;
            if (wr_cnt_en) cnt_q <= wr_cnt;
            else if (any_edge) cnt_q <= cnt_q + CNT_ONE;
            if (!phase_high) out_bit <= data_q[DATA_W-1];
        end
    end
endmodule

// File: rtl/sershift_hold_ctrl.sv
module sershift_hold_ctrl
    import sershift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        two_wire,
    input  logic        slave,
    input  logic        start_flag,
    input  logic        ovf_flag,
    output hold_state_e state,
    output logic        hold
);
    hold_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HOLD_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            HOLD_FREE: begin
                if (two_wire && start_flag && slave) state_nx = HOLD_START;
                else if (two_wire && ovf_flag)       state_nx = HOLD_OVF;
            end
            HOLD_START: begin
                if (!two_wire)       state_nx = HOLD_FREE;
                else if (!start_flag) state_nx = ovf_flag ? HOLD_OVF : HOLD_FREE;
            end
            HOLD_OVF: begin
                if (!two_wire)                 state_nx = HOLD_FREE;
                else if (start_flag && slave)  state_nx = HOLD_START;
                else if (!ovf_flag)            state_nx = HOLD_FREE;
            end
            default: state_nx = HOLD_FREE;
        endcase
    end

    always_comb begin
        unique case (state)
            HOLD_START, HOLD_OVF: hold = 1'b1;
            default:              hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/sershift_unit.sv
module sershift_unit
    import sershift_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              two_wire,
    input  logic [1:0]        clk_src,
    input  logic              sw_strobe,
    input  logic              tmr_match,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_cnt_en,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic              clr_start,
    input  logic              clr_ovf,
    input  logic              start_ie,
    input  logic              ovf_ie,
    input  logic              di_pin,
    input  logic              sda_pin,
    input  logic              sclk_pin,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] buf_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              irq,
    output logic              do_pin,
    output logic              sda_drive_low,
    output logic              scl_drive_low,
    output logic              sck_out
);
    clk_src_e    src;
    hold_state_e hold_state;
    logic sample_edge, output_edge, phase_high, int_clk;
    logic scl_s, sda_s, di_s, sda_fall;
    logic out_bit, ovf_event, hold, start_set, master_low;

    assign src = clk_src_e'(clk_src);

    sershift_edge_gen #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .src(src), .sw_strobe(sw_strobe),
        .tmr_match(tmr_match), .sclk_pin(sclk_pin), .sda_pin(sda_pin),
        .di_pin(di_pin), .sample_edge(sample_edge), .output_edge(output_edge),
        .phase_high(phase_high), .int_clk(int_clk), .scl_s(scl_s),
        .sda_s(sda_s), .di_s(di_s), .sda_fall(sda_fall)
    );

    sershift_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_data (
        .clk(clk), .rst_n(rst_n), .wr_data_en(wr_data_en), .wr_data(wr_data),
        .wr_cnt_en(wr_cnt_en), .wr_cnt(wr_cnt), .sample_edge(sample_edge),
        .output_edge(output_edge), .phase_high(phase_high),
        .serial_in(two_wire ? sda_s : di_s), .data_q(data_q), .buf_q(buf_q),
        .cnt_q(cnt_q), .out_bit(out_bit), .ovf_event(ovf_event)
    );

    sershift_hold_ctrl u_hold (
        .clk(clk), .rst_n(rst_n), .two_wire(two_wire),
        .slave(src == SRC_PIN), .start_flag(start_flag), .ovf_flag(ovf_flag),
        .state(hold_state), .hold(hold)
    );

    assign start_set = two_wire && sda_fall && scl_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            ovf_flag   <= 1'b0;
        end else begin
            start_flag <= start_set || (start_flag && !clr_start);
            ovf_flag   <= ovf_event || (ovf_flag && !clr_ovf);
        end
    end

    assign master_low    = ((src == SRC_SOFT) || (src == SRC_TIMER)) && !int_clk;
    assign irq           = (start_flag && start_ie) || (ovf_flag && ovf_ie);
    assign do_pin        = !two_wire && out_bit;
    assign sda_drive_low = two_wire && !out_bit;
    assign scl_drive_low = two_wire && (hold || master_low);
    assign sck_out       = int_clk;
endmodule

// File: rtl/sershift_checks.sv
module sershift_checks #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              two_wire,
    input logic              sample_edge,
    input logic              output_edge,
    input logic              wr_cnt_en,
    input logic              wr_data_en,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] buf_q,
    input logic              ovf_event,
    input logic              ovf_flag,
    input logic              start_flag,
    input logic              start_ie,
    input logic              irq,
    input logic              phase_high,
    input logic              out_bit,
    input logic              hold,
    input logic              sda_drive_low,
    input logic              scl_drive_low
);
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && (sample_edge || output_edge) && !wr_cnt_en) |=> (cnt_q == '0 && ovf_flag));

    p_buf_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_event && !wr_data_en) |=> (buf_q == data_q));

    p_latch_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(phase_high) |-> $stable(out_bit));

    p_three_wire_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !two_wire |-> (!sda_drive_low && !scl_drive_low));

    p_no_start_three_wire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_wire && !start_flag) |=> !start_flag);

    p_hold_pulls_scl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> scl_drive_low);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_event |=> ovf_flag);

    p_irq_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && start_ie) |-> irq);
endmodule

bind sershift_unit sershift_checks #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_checks (
    .clk(clk), .rst_n(rst_n), .two_wire(two_wire), .sample_edge(sample_edge),
    .output_edge(output_edge), .wr_cnt_en(wr_cnt_en), .wr_data_en(wr_data_en),
    .cnt_q(cnt_q), .data_q(data_q), .buf_q(buf_q), .ovf_event(ovf_event),
    .ovf_flag(ovf_flag), .start_flag(start_flag), .start_ie(start_ie), .irq(irq),
    .phase_high(phase_high), .out_bit(out_bit), .hold(hold),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low)
);

// File: tb/test_sershift_unit.sv
module test_sershift_unit;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, two_wire, sw_strobe, tmr_match, wr_data_en, wr_cnt_en;
    logic clr_start, clr_ovf, start_ie, ovf_ie, di_pin, sda_pin, sclk_pin;
    logic [1:0] clk_src;
    logic [7:0] wr_data, data_q, buf_q;
    logic [3:0] wr_cnt, cnt_q;
    logic start_flag, ovf_flag, irq, do_pin, sda_drive_low, scl_drive_low, sck_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [15:0] VECS [0:3] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E};

    sershift_unit i_sershift_unit (
        .clk(clk), .rst_n(rst_n), .two_wire(two_wire), .clk_src(clk_src),
        .sw_strobe(sw_strobe), .tmr_match(tmr_match), .wr_data_en(wr_data_en),
        .wr_data(wr_data), .wr_cnt_en(wr_cnt_en), .wr_cnt(wr_cnt),
        .clr_start(clr_start), .clr_ovf(clr_ovf), .start_ie(start_ie),
        .ovf_ie(ovf_ie), .di_pin(di_pin), .sda_pin(sda_pin), .sclk_pin(sclk_pin),
        .data_q(data_q), .buf_q(buf_q), .cnt_q(cnt_q), .start_flag(start_flag),
        .ovf_flag(ovf_flag), .irq(irq), .do_pin(do_pin),
        .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low), .sck_out(sck_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic tw, input logic [1:0] src);
        @(negedge clk);
        rst_n = 1'b0; two_wire = tw; clk_src = src;
        sw_strobe = 0; tmr_match = 0; wr_data_en = 0; wr_cnt_en = 0;
        wr_data = 0; wr_cnt = 0; clr_start = 0; clr_ovf = 0;
        start_ie = 0; ovf_ie = 0; di_pin = 0; sda_pin = 1; sclk_pin = 1;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic sw_tick();
        @(negedge clk) sw_strobe = 1'b1;
        @(negedge clk) sw_strobe = 1'b0;
        wait_n(2);
    endtask

    task automatic tmr_tick();
        @(negedge clk) tmr_match = 1'b1;
        @(negedge clk) tmr_match = 1'b0;
        wait_n(2);
    endtask

    task automatic host_data(input logic [7:0] v);
        @(negedge clk) begin wr_data = v; wr_data_en = 1'b1; end
        @(negedge clk) wr_data_en = 1'b0;
    endtask

    task automatic host_cnt(input logic [3:0] v);
        @(negedge clk) begin wr_cnt = v; wr_cnt_en = 1'b1; end
        @(negedge clk) wr_cnt_en = 1'b0;
    endtask

    task automatic pulse_clr_ovf();
        @(negedge clk) clr_ovf = 1'b1;
        @(negedge clk) clr_ovf = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] obs;
        // R1: reset state
        do_reset(1'b0, 2'd0);
        chk("R1 reset state",
            {data_q, buf_q, cnt_q, start_flag, ovf_flag, irq, do_pin, sck_out, sda_drive_low, scl_drive_low},
            {8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});

        // Vector table: three-wire software-strobed full-duplex bytes (R3 R4 R5 R6)
        for (int v = 0; v < 4; v++) begin
            host_data(VECS[v][15:8]);
            host_cnt(4'd0);
            pulse_clr_ovf();
            obs = 8'h00;
            for (int b = 7; b >= 0; b--) begin
                sw_tick();
                obs[b] = do_pin;
                @(negedge clk) di_pin = VECS[v][b];
                wait_n(3);
                sw_tick();
            end
            chk("R6 serial out bits MSB first", {24'h0, obs}, {24'h0, VECS[v][15:8]});
            chk("R4 shifted-in byte", {24'h0, data_q}, {24'h0, VECS[v][7:0]});
            chk("R5 buffer capture", {24'h0, buf_q}, {24'h0, VECS[v][7:0]});
            chk("R3 wrap and overflow", {27'h0, cnt_q, ovf_flag}, {27'h0, 4'h0, 1'b1});
        end

        // R2 host writes and R3 wrap from a preset count
        do_reset(1'b0, 2'd0);
        host_data(8'h12);
        host_cnt(4'd14);
        chk("R2 host write data/count", {20'h0, data_q, cnt_q}, {20'h0, 8'h12, 4'd14});
        sw_tick();
        sw_tick();
        chk("R3 wrap 15 to 0", {27'h0, cnt_q, ovf_flag}, {27'h0, 4'h0, 1'b1});
        @(negedge clk) begin wr_cnt = 4'd5; wr_cnt_en = 1'b1; sw_strobe = 1'b1; end
        @(negedge clk) begin wr_cnt_en = 1'b0; sw_strobe = 1'b0; end
        chk("R2 host count beats edge", {28'h0, cnt_q}, {28'h0, 4'd5});

        // R11 set beats clear, irq gating
        pulse_clr_ovf();
        host_cnt(4'd15);
        @(negedge clk) begin sw_strobe = 1'b1; clr_ovf = 1'b1; end
        @(negedge clk) begin sw_strobe = 1'b0; clr_ovf = 1'b0; end
        chk("R11 overflow set wins over clear", {31'h0, ovf_flag}, 32'h1);
        chk("R11 irq masked", {31'h0, irq}, 32'h0);
        @(negedge clk) ovf_ie = 1'b1;
        @(negedge clk);
        chk("R11 irq from overflow", {31'h0, irq}, 32'h1);

        // R6 latch closed while clock high
        do_reset(1'b0, 2'd0);
        host_data(8'h00);
        wait_n(2);
        chk("R6 output held while clock high", {31'h0, do_pin}, 32'h1);
        sw_tick();
        chk("R6 output follows while clock low", {31'h0, do_pin}, 32'h0);

        // R7 timer source, strobes ignored
        do_reset(1'b0, 2'd2);
        di_pin = 1'b1;
        sw_tick();
        sw_tick();
        chk("R7 strobe ignored in timer mode", {28'h0, cnt_q}, 32'h0);
        for (int k = 0; k < 16; k++) tmr_tick();
        chk("R7 timer clocked byte", {23'h0, buf_q, ovf_flag}, {23'h0, 8'hFF, 1'b1});

        // R9 R10 R11: two-wire slave start detect and hold
        do_reset(1'b1, 2'd1);
        start_ie = 1'b1;
        @(negedge clk) sda_pin = 1'b0;
        wait_n(6);
        chk("R9 start flag and R11 irq", {30'h0, start_flag, irq}, {30'h0, 2'b11});
        chk("R10 SCL held after start", {31'h0, scl_drive_low}, 32'h1);
        @(negedge clk) clr_start = 1'b1;
        @(negedge clk) clr_start = 1'b0;
        wait_n(3);
        chk("R10 SCL released after clear", {30'h0, start_flag, scl_drive_low}, 32'h0);

        // R4 R10: receive 0xC3 over two-wire with pin clock
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk) sclk_pin = 1'b0;
            wait_n(4);
            sda_pin = 8'hC3 >> b;
            wait_n(4);
            sclk_pin = 1'b1;
            wait_n(4);
        end
        chk("R4 two-wire byte from SDA", {16'h0, buf_q, data_q}, {16'h0, 8'hC3, 8'hC3});
        chk("R10 SCL held after overflow", {30'h0, ovf_flag, scl_drive_low}, {30'h0, 2'b11});
        pulse_clr_ovf();
        wait_n(3);
        chk("R10 SCL released after overflow clear", {31'h0, scl_drive_low}, 32'h0);

        // R8 open-drain data output
        @(negedge clk) sclk_pin = 1'b0;
        wait_n(4);
        host_data(8'h00);
        wait_n(3);
        chk("R8 SDA pulled low for 0", {30'h0, sda_drive_low, do_pin}, {30'h0, 2'b10});
        host_data(8'h80);
        wait_n(3);
        chk("R8 SDA released for 1", {31'h0, sda_drive_low}, 32'h0);

        // R9: no start in three-wire mode
        do_reset(1'b0, 2'd1);
        @(negedge clk) sda_pin = 1'b0;
        wait_n(6);
        chk("R9 no start in three-wire", {31'h0, start_flag}, 32'h0);

        // R12 master clock in two-wire software mode
        do_reset(1'b1, 2'd0);
        sw_tick();
        chk("R12 clock low drives SCL", {30'h0, sck_out, scl_drive_low}, {30'h0, 2'b01});
        sw_tick();
        chk("R12 clock high releases SCL", {30'h0, sck_out, scl_drive_low}, {30'h0, 2'b10});

        finish_run();
    end
endmodule